// File: doc/BRIEF.md
# Quad Texture Level-of-Detail Selector

This block turns the texture coordinates of a 2x2 pixel quad into a mip level and a blend weight for each of the four pixels. It is a streaming stage with a valid/ready handshake on each side. It accepts one quad per cycle and returns results after a fixed three-cycle latency.

In the default quad mode, the block builds an x derivative from one row of the quad and a y derivative from one column. It takes the absolute derivatives for both u and v, scales them to texel units and keeps the largest as the footprint. A piecewise-linear log2 of that footprint gives a single LOD, which all four pixels share.

Two further modes work per pixel. In explicit-LOD mode, each pixel's supplied LOD is used as it is. In explicit-derivative mode, each pixel uses its own supplied derivatives. After clamping, an optional similarity rule collapses the four results onto the finest of them when they lie within a programmable spread.

Top module: `lod_quad_sel`

## Requirements
- R1: In quad mode (`mode_i` = 0, and also the unused code 3), all four pixels of a beat receive the same level and weight. Pixel lanes are numbered 0 top-left, 1 top-right, 2 bottom-left and 3 bottom-right. Lane i occupies bits [i*W +: W] of every packed port.
- R2: The x difference is lane1 − lane0 when `row_sel_i` = 0 and lane3 − lane2 when it is 1. The y difference is lane2 − lane0 when `col_sel_i` = 0 and lane3 − lane1 when it is 1.
- R3: The footprint is the maximum of |du|·2^`log2_w_i` and |dv|·2^`log2_h_i`, taken over both the x and y differences. A quad that varies only in v, or only along y, still yields a nonzero LOD.
- R4: For a nonzero footprint m with leading one at bit p, the LOD is 16·(p − 12) plus the four bits of m just below bit p (zero-filled when p < 4). This is a signed value with 4 fraction bits for 12-fraction-bit coordinates. A zero footprint gives LOD 0.
- R5: The LOD is clamped to [0, 16·`max_level_i`]. The pixel's level is the clamped value divided by 16 and its weight is the remainder.
- R6: In explicit-LOD mode (`mode_i` = 1), each lane's signed 9-bit `lod_x_i` value (4 fraction bits) is clamped per R5 and used on its own, with no sharing.
- R7: In explicit-derivative mode (`mode_i` = 2), each lane uses its own four gradient fields in `grad_i`. Field k of lane i sits at bits [(4i+k)*16 +: 16], with k = 0 du/dx, 1 dv/dx, 2 du/dy and 3 dv/dy. The lane's footprint is computed per R3 and R4.
- R8: With `sim_en_i` = 1, if the largest and smallest of the four clamped LODs differ by at most `sim_thr_i` (inclusive), every lane takes the smallest one. Otherwise the lanes keep their own LODs.
- R9: After reset `out_valid_o` is 0 and `in_ready_o` is 1. A beat accepted at clock edge k is presented from edge k+2, and a new beat may be accepted on every edge.
- R10: While `out_valid_o` = 1 and `out_ready_i` = 0, the outputs hold their values, `in_ready_o` is 0, and no beat is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high with valid |
| mode_i | input | 2 | 0 quad, 1 explicit LOD, 2 explicit derivatives, 3 as 0 |
| row_sel_i | input | 1 | x difference row: 0 top, 1 bottom |
| col_sel_i | input | 1 | y difference column: 0 left, 1 right |
| log2_w_i | input | 4 | log2 texture width |
| log2_h_i | input | 4 | log2 texture height |
| max_level_i | input | 4 | Highest mip level |
| sim_en_i | input | 1 | Enable similarity collapse |
| sim_thr_i | input | 8 | Similarity spread limit, 4 fraction bits |
| u_i | input | 64 | Four signed u coordinates, 12 fraction bits |
| v_i | input | 64 | Four signed v coordinates, 12 fraction bits |
| lod_x_i | input | 36 | Four signed explicit LODs |
| grad_i | input | 256 | Four sets of signed explicit derivatives |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream ready |
| level_o | output | 16 | Four integer mip levels |
| weight_o | output | 16 | Four 4-bit blend weights |

## Verification
The assertions check on every cycle that a stalled result stays frozen and that no beat is taken in while the output is blocked. They also check that quad-mode results agree across all four lanes and that no level exceeds the maximum that travelled with its beat. The bench's scenarios are needed for the remaining behaviours:
- the row and column choices and the u/v and x/y contributions to the footprint;
- the exact log2 fraction values across thousands of footprints;
- the inclusive edge of the similarity threshold;
- the explicit modes;
- the latency and back-to-back throughput counts.

// File: rtl/lod_pkg.sv
package lod_pkg;
  localparam int NPIX = 4;
  typedef enum logic [1:0] {
    MODE_QUAD  = 2'd0,
    MODE_XLOD  = 2'd1,
    MODE_XGRAD = 2'd2,
    MODE_RSVD  = 2'd3
  } lod_mode_e;
endpackage

// File: rtl/lod_footprint.sv
module lod_footprint
  import lod_pkg::*;
#(
  parameter int CW   = 16,
  parameter int LW_W = 4,
  parameter int SW   = CW + (1 << LW_W)
) (
  input  logic [NPIX*CW-1:0]   u_i,
  input  logic [NPIX*CW-1:0]   v_i,
  input  logic [4*NPIX*CW-1:0] grad_i,
  input  lod_mode_e            mode_i,
  input  logic                 row_sel_i,
  input  logic                 col_sel_i,
  input  logic [LW_W-1:0]      lw_i,
  input  logic [LW_W-1:0]      lh_i,
  output logic [NPIX*SW-1:0]   mag_o
);
  function automatic logic signed [CW:0] diff(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return $signed({a[CW-1], a}) - $signed({b[CW-1], b});
  endfunction

  function automatic logic [SW-1:0] scl(input logic signed [CW:0] d, input logic [LW_W-1:0] s);
    logic [CW:0] a;
    a = d[CW] ? $unsigned(-d) : $unsigned(d);
    return SW'(a) << s;
  endfunction

  function automatic logic [SW-1:0] mx(input logic [SW-1:0] a, input logic [SW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CW-1:0] uu [NPIX];
  logic [CW-1:0] vv [NPIX];
  logic [1:0]    r0, c0;
  logic [SW-1:0] quad_m;

  always_comb begin
    for (int i = 0; i < NPIX; i++) begin
      uu[i] = u_i[i*CW +: CW];
      vv[i] = v_i[i*CW +: CW];
    end
    r0 = row_sel_i ? 2'd2 : 2'd0;
    c0 = {1'b0, col_sel_i};
    quad_m = mx(mx(scl(diff(uu[r0 + 2'd1], uu[r0]), lw_i),
                   scl(diff(vv[r0 + 2'd1], vv[r0]), lh_i)),
                mx(scl(diff(uu[c0 + 2'd2], uu[c0]), lw_i),
                   scl(diff(vv[c0 + 2'd2], vv[c0]), lh_i)));
  end

  for (genvar i = 0; i < NPIX; i++) begin : g_pix
    logic [CW-1:0] g [4];
    logic [SW-1:0] pix_m;
    always_comb begin
      for (int k = 0; k < 4; k++) g[k] = grad_i[(4*i+k)*CW +: CW];
      pix_m = mx(mx(scl({g[0][CW-1], g[0]}, lw_i), scl({g[1][CW-1], g[1]}, lh_i)),
                 mx(scl({g[2][CW-1], g[2]}, lw_i), scl({g[3][CW-1], g[3]}, lh_i)));
      mag_o[i*SW +: SW] = (mode_i == MODE_XGRAD) ? pix_m : quad_m;
    end
  end
endmodule

// File: rtl/lod_log2.sv
module lod_log2 #(
  parameter int SW    = 32,
  parameter int CFRAC = 12,
  parameter int LOG_W = 11
) (
  input  logic [SW-1:0]           mag_i,
  output logic signed [LOG_W-1:0] lod_o
);
  int            p;
  int            t;
  logic [SW-1:0] norm;
  logic [3:0]    fr;

  always_comb begin
    p = 0;
    for (int b = 0; b < SW; b++) if (mag_i[b]) p = b;
    norm  = mag_i << (SW - 1 - p);   // leading one to msb, mantissa follows
    fr    = norm[SW-2 -: 4];
    t     = (p - CFRAC) * 16 + int'(fr);
    lod_o = (mag_i == '0) ? '0 : LOG_W'(t);
  end
endmodule

// File: rtl/lod_unify.sv
module lod_unify
  import lod_pkg::*;
#(
  parameter int CL_W = 8
) (
  input  logic [NPIX*CL_W-1:0] lod_i,
  input  logic                 en_i,
  input  logic [CL_W-1:0]      thr_i,
  output logic [NPIX*CL_W-1:0] lod_o
);
  logic [CL_W-1:0] mn, mxv, cur;
  logic            force_one;

  always_comb begin
    mn  = lod_i[0 +: CL_W];
    mxv = lod_i[0 +: CL_W];
    for (int i = 1; i < NPIX; i++) begin
      cur = lod_i[i*CL_W +: CL_W];
      if (cur < mn)  mn  = cur;
      if (cur > mxv) mxv = cur;
    end
    force_one = en_i && ((mxv - mn) <= thr_i);
    for (int i = 0; i < NPIX; i++)
      lod_o[i*CL_W +: CL_W] = force_one ? mn : lod_i[i*CL_W +: CL_W];
  end
endmodule

// File: rtl/lod_quad_sel.sv
module lod_quad_sel
  import lod_pkg::*;
#(
  parameter int CW     = 16,
  parameter int CFRAC  = 12,
  parameter int LW_W   = 4,
  parameter int LVL_W  = 4,
  parameter int LODX_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [1:0]              mode_i,
  input  logic                    row_sel_i,
  input  logic                    col_sel_i,
  input  logic [LW_W-1:0]         log2_w_i,
  input  logic [LW_W-1:0]         log2_h_i,
  input  logic [LVL_W-1:0]        max_level_i,
  input  logic                    sim_en_i,
  input  logic [LVL_W+3:0]        sim_thr_i,
  input  logic [4*CW-1:0]         u_i,
  input  logic [4*CW-1:0]         v_i,
  input  logic [4*LODX_W-1:0]     lod_x_i,
  input  logic [16*CW-1:0]        grad_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [4*LVL_W-1:0]      level_o,
  output logic [4*4-1:0]          weight_o
);
  localparam int SW    = CW + (1 << LW_W);
  localparam int CL_W  = LVL_W + 4;
  localparam int LOG_W = $clog2(SW) + 6;

  logic adv;
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;

  // stage 1: footprint magnitudes
  lod_mode_e            mode_in, mode1_q, mode2_q, mode3_q;
  logic [NPIX*SW-1:0]   mag_d, mag1_q;
  logic [NPIX*LODX_W-1:0] lodx1_q;
  logic                 v1_q, v2_q, sim1_q, sim2_q;
  logic [CL_W-1:0]      thr1_q, thr2_q;
  logic [LVL_W-1:0]     ml1_q, ml2_q, ml3_q;

  assign mode_in = lod_mode_e'(mode_i);

  lod_footprint #(.CW(CW), .LW_W(LW_W), .SW(SW)) u_fp (
    .u_i(u_i), .v_i(v_i), .grad_i(grad_i), .mode_i(mode_in),
    .row_sel_i(row_sel_i), .col_sel_i(col_sel_i),
    .lw_i(log2_w_i), .lh_i(log2_h_i), .mag_o(mag_d)
  );

  // stage 2: log2, explicit select, clamp
  logic [NPIX*CL_W-1:0] cl_d, cl2_q, un_d;
  logic signed [LOG_W-1:0] ceil_s;
  assign ceil_s = $signed({{(LOG_W-CL_W){1'b0}}, ml1_q, 4'b0000});

  for (genvar i = 0; i < NPIX; i++) begin : g_lane
    logic signed [LOG_W-1:0] lg, raw;
    lod_log2 #(.SW(SW), .CFRAC(CFRAC), .LOG_W(LOG_W)) u_lg (
      .mag_i(mag1_q[i*SW +: SW]), .lod_o(lg)
    );
    always_comb begin
      raw = (mode1_q == MODE_XLOD) ? LOG_W'($signed(lodx1_q[i*LODX_W +: LODX_W])) : lg;
      if (raw < 0)            cl_d[i*CL_W +: CL_W] = '0;
      else if (raw > ceil_s)  cl_d[i*CL_W +: CL_W] = ceil_s[CL_W-1:0];
      else                    cl_d[i*CL_W +: CL_W] = raw[CL_W-1:0];
    end
  end

  // stage 3: similarity collapse and split
  lod_unify #(.CL_W(CL_W)) u_un (
    .lod_i(cl2_q), .en_i(sim2_q), .thr_i(thr2_q), .lod_o(un_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q        <= 1'b0;
      v2_q        <= 1'b0;
      out_valid_o <= 1'b0;
    end else if (adv) begin
      v1_q        <= in_valid_i;
      v2_q        <= v1_q;
      out_valid_o <= v2_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (adv) begin
      mag1_q  <= mag_d;
      lodx1_q <= lod_x_i;
      mode1_q <= mode_in;
      sim1_q  <= sim_en_i;
      thr1_q  <= sim_thr_i;
      ml1_q   <= max_level_i;
      cl2_q   <= cl_d;
      mode2_q <= mode1_q;
      sim2_q  <= sim1_q;
      thr2_q  <= thr1_q;
      ml2_q   <= ml1_q;
      mode3_q <= mode2_q;
      ml3_q   <= ml2_q;
      for (int i = 0; i < NPIX; i++) begin
        level_o[i*LVL_W +: LVL_W] <= un_d[i*CL_W+4 +: LVL_W];
        weight_o[i*4 +: 4]        <= un_d[i*CL_W +: 4];
      end
    end
  end

  // R10: blocked result is frozen
  assert_hold_stalled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(level_o) && $stable(weight_o));

  // R10: nothing enters while the output is blocked
  assert_no_accept_stalled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  // R1: quad mode lanes agree
  assert_quad_shared_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (mode3_q == MODE_QUAD || mode3_q == MODE_RSVD) |->
      level_o[0 +: LVL_W] == level_o[LVL_W +: LVL_W] &&
      level_o[0 +: LVL_W] == level_o[2*LVL_W +: LVL_W] &&
      level_o[0 +: LVL_W] == level_o[3*LVL_W +: LVL_W] &&
      weight_o[3:0] == weight_o[7:4] && weight_o[3:0] == weight_o[11:8] &&
      weight_o[3:0] == weight_o[15:12]);

  for (genvar i = 0; i < NPIX; i++) begin : g_chk
    // R5: no level beyond the beat's maximum
    assert_level_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> level_o[i*LVL_W +: LVL_W] <= ml3_q);
  end
endmodule

// File: tb/tb_lod_quad_sel.sv
module tb_lod_quad_sel;
  localparam int CW = 16, CF = 12, LWW = 4, LVL = 4, LXW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [1:0]        mode = 2'd0;
  logic              row_sel = 1'b0, col_sel = 1'b0, sim_en = 1'b0;
  logic [LWW-1:0]    lw = '0, lh = '0;
  logic [LVL-1:0]    ml = '0;
  logic [LVL+3:0]    thr = '0;
  logic [4*CW-1:0]   u = '0, v = '0;
  logic [4*LXW-1:0]  lx = '0;
  logic [16*CW-1:0]  gr = '0;
  logic [4*LVL-1:0]  level;
  logic [15:0]       weight;

  lod_quad_sel dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .mode_i(mode), .row_sel_i(row_sel), .col_sel_i(col_sel),
    .log2_w_i(lw), .log2_h_i(lh), .max_level_i(ml), .sim_en_i(sim_en),
    .sim_thr_i(thr), .u_i(u), .v_i(v), .lod_x_i(lx), .grad_i(gr),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .level_o(level), .weight_o(weight)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0, rand_rdy = 1'b0;
  string cur_tag = "R1";
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic longint sc(int d, int s);
    longint a = (d < 0) ? -d : d;
    return a << s;
  endfunction
  function automatic longint lmax(longint a, longint b);
    return (a > b) ? a : b;
  endfunction
  function automatic int lg(longint m);
    int p = 0;
    if (m == 0) return 0;
    for (int b = 0; b < 63; b++) if (m[b]) p = b;
    return (p - CF) * 16 + int'(((m << 4) >> p) & 15);
  endfunction
  function automatic int cl(int x, int mlv);
    if (x < 0) return 0;
    if (x > mlv * 16) return mlv * 16;
    return x;
  endfunction

  function automatic logic [31:0] model();
    int c[4], uu[4], vv[4], r0, c0, mn, mx;
    longint m;
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      uu[i] = int'($signed(u[i*CW +: CW]));
      vv[i] = int'($signed(v[i*CW +: CW]));
    end
    if (mode == 2'd1) begin
      for (int i = 0; i < 4; i++) c[i] = cl(int'($signed(lx[i*LXW +: LXW])), int'(ml));
    end else if (mode == 2'd2) begin
      for (int i = 0; i < 4; i++) begin
        m = lmax(lmax(sc(int'($signed(gr[(4*i)*CW +: CW])), int'(lw)),
                      sc(int'($signed(gr[(4*i+1)*CW +: CW])), int'(lh))),
                 lmax(sc(int'($signed(gr[(4*i+2)*CW +: CW])), int'(lw)),
                      sc(int'($signed(gr[(4*i+3)*CW +: CW])), int'(lh))));
        c[i] = cl(lg(m), int'(ml));
      end
    end else begin
      r0 = row_sel ? 2 : 0;
      c0 = col_sel ? 1 : 0;
      m = lmax(lmax(sc(uu[r0+1] - uu[r0], int'(lw)), sc(vv[r0+1] - vv[r0], int'(lh))),
               lmax(sc(uu[c0+2] - uu[c0], int'(lw)), sc(vv[c0+2] - vv[c0], int'(lh))));
      for (int i = 0; i < 4; i++) c[i] = cl(lg(m), int'(ml));
    end
    if (sim_en) begin
      mn = c[0]; mx = c[0];
      for (int i = 1; i < 4; i++) begin
        if (c[i] < mn) mn = c[i];
        if (c[i] > mx) mx = c[i];
      end
      if (mx - mn <= int'(thr)) for (int i = 0; i < 4; i++) c[i] = mn;
    end
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = 8'(c[i]);
    return r;
  endfunction

  function automatic logic [31:0] got_now();
    logic [31:0] g;
    for (int i = 0; i < 4; i++) g[i*8 +: 8] = {level[i*4 +: 4], weight[i*4 +: 4]};
    return g;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard, sampled mid-cycle
  bit          stall_prev = 1'b0;
  logic [31:0] prev_got = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stall_prev)
        chk("R10 hold", {31'd0, out_valid} ^ (got_now() ^ prev_got) ^ 32'd1, 32'd0);
      if (out_valid && !out_ready) chk("R10 in_ready low", {31'd0, in_ready}, 32'd0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk("R10 extra output", 32'd1, 32'd0);
        else chk(tag_q.pop_front(), got_now(), exp_q.pop_front());
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model());
        tag_q.push_back(cur_tag);
      end
      stall_prev = out_valid && !out_ready;
      prev_got   = got_now();
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = rand_rdy ? 1'($urandom % 2) : 1'b1;
    end
  end

  task automatic send();
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    rand_rdy = 1'b0;
    repeat (2) @(posedge clk);
    while (exp_q.size() != 0) @(posedge clk);
    #1;
  endtask

  task automatic rnd_quad(int span);
    int base = int'($urandom % 8192) - 4096;
    for (int i = 0; i < 4; i++) begin
      u[i*CW +: CW] = 16'(base + int'($urandom % span));
      v[i*CW +: CW] = 16'(base + int'($urandom % span));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R9 reset ready", {31'd0, in_ready}, 32'd1);
    @(posedge clk); #1;

    // R1/R3: random implicit quads, both row/column choices
    cur_tag = "R1 quad sweep";
    for (int n = 0; n < 400; n++) begin
      mode = (n % 7 == 0) ? 2'd3 : 2'd0;
      row_sel = 1'($urandom % 2); col_sel = 1'($urandom % 2);
      lw = 4'($urandom % 16); lh = 4'($urandom % 16); ml = 4'($urandom % 16);
      rnd_quad(1 << (n % 12 + 1));
      send();
    end
    drain();

    // R2: rows differ (16 vs 256), columns differ (0 vs 240)
    cur_tag = "R2 row/col select";
    mode = 2'd0; lw = 4'd12; lh = 4'd0; ml = 4'd15; v = '0;
    u = {16'd256, 16'd0, 16'd16, 16'd0};
    for (int s = 0; s < 4; s++) begin
      row_sel = s[0]; col_sel = s[1];
      send();
    end
    drain();

    // R3: only v varying along y; only u along x; scaling sweep
    cur_tag = "R3 v-only y";
    u = '0; v = {16'd64, 16'd64, 16'd0, 16'd0}; lh = 4'd10; lw = 4'd0;
    row_sel = 1'b0; col_sel = 1'b0; send();
    cur_tag = "R3 scale sweep";
    u = {16'd0, 16'd3, 16'd0, 16'd3}; v = '0;
    for (int s = 0; s < 16; s++) begin
      lw = 4'(s); lh = 4'(15 - s); send();
    end
    drain();

    // R4: exhaustive footprints 0..2047 with 2^12 scale
    cur_tag = "R4 log2";
    lw = 4'd12; lh = 4'd0; ml = 4'd15; v = '0;
    for (int k = 0; k < 2048; k++) begin
      u = {16'd0, 16'd0, 16'(k), 16'd0};
      send();
    end
    drain();

    // R5: clamp top and bottom over every max level
    cur_tag = "R5 clamp";
    for (int s = 0; s < 16; s++) begin
      ml = 4'(s); lw = 4'd15;
      u = {16'd0, 16'd0, 16'h7fff, 16'h8000}; send();
      lw = 4'd0; u = {16'd0, 16'd0, 16'd5, 16'd0}; send();
    end
    drain();

    // R6: explicit LOD lanes across the signed range
    cur_tag = "R6 explicit lod";
    mode = 2'd1;
    for (int k = 0; k < 128; k++) begin
      ml = 4'(k % 16);
      for (int i = 0; i < 4; i++) lx[i*LXW +: LXW] = 9'((k * 4 + i) * 4 - 256 + i * 37);
      send();
    end
    drain();

    // R7: explicit derivatives per lane
    cur_tag = "R7 explicit grad";
    mode = 2'd2;
    for (int n = 0; n < 200; n++) begin
      lw = 4'($urandom % 16); lh = 4'($urandom % 16); ml = 4'($urandom % 16);
      for (int j = 0; j < 16; j++) gr[j*CW +: CW] = 16'($urandom >> ($urandom % 28));
      send();
    end
    drain();

    // R8: similarity threshold boundary (spread 24) and random
    cur_tag = "R8 similarity edge";
    mode = 2'd1; ml = 4'd15; sim_en = 1'b1;
    lx = {9'd64, 9'd50, 9'd40, 9'd60};
    thr = 8'd24; send();
    thr = 8'd23; send();
    thr = 8'd0; lx = {9'd40, 9'd40, 9'd40, 9'd40}; send();
    cur_tag = "R8 similarity random";
    for (int n = 0; n < 200; n++) begin
      mode = 2'(1 + (n % 2)); thr = 8'($urandom % 64);
      for (int i = 0; i < 4; i++) lx[i*LXW +: LXW] = 9'(60 + $urandom % 80);
      for (int j = 0; j < 16; j++) gr[j*CW +: CW] = 16'($urandom >> ($urandom % 24));
      lw = 4'($urandom % 16); lh = 4'($urandom % 16);
      send();
    end
    sim_en = 1'b0;
    drain();

    // R9: latency three edges, then back-to-back acceptance
    cur_tag = "R9 latency";
    mode = 2'd1; lx = '0; send();
    in_valid = 1'b0;
    @(negedge clk); chk("R9 lat edge k", {31'd0, out_valid}, 32'd0);
    @(negedge clk); chk("R9 lat edge k+1", {31'd0, out_valid}, 32'd0);
    @(negedge clk); chk("R9 lat edge k+2", {31'd0, out_valid}, 32'd1);
    drain();
    cur_tag = "R9 stream";
    for (int n = 0; n < 16; n++) begin
      lx = 36'($urandom);
      in_valid = 1'b1;
      @(negedge clk); chk("R9 ready streaming", {31'd0, in_ready}, 32'd1);
      @(posedge clk); #1;
    end
    drain();

    // R10: random backpressure over mixed traffic
    cur_tag = "R10 backpressure";
    rand_rdy = 1'b1;
    for (int n = 0; n < 300; n++) begin
      mode = 2'($urandom % 3); sim_en = 1'($urandom % 2); thr = 8'($urandom % 32);
      row_sel = 1'($urandom % 2); col_sel = 1'($urandom % 2);
      lw = 4'($urandom % 16); lh = 4'($urandom % 16); ml = 4'($urandom % 16);
      rnd_quad(1 << (n % 10 + 1));
      lx = 36'($urandom);
      for (int j = 0; j < 16; j++) gr[j*CW +: CW] = 16'($urandom >> ($urandom % 24));
      send();
    end
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL R9: watchdog expired, actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule